// File: doc/BRIEF.md
# Clock Source Control Register

This block is a byte-wide read/write control register that chooses where the system clock and the slow clock come from, and that switches the PLL on or off. Its outputs drive the select inputs of an external glitch-free clock multiplexer, the PLL power-down line and two auxiliary clock gates. Software writes the register through a simple bus made of a write enable, write data and combinational read data.

Two of the bits are guarded by hardware interlocks. One selects between the main clock and the PLL. The other powers the PLL down. A small state machine holds the legal combinations of these two bits:

- `ST_MAIN_PLL_OFF`: main clock selected, PLL off.
- `ST_MAIN_PLL_ON`: main clock selected, PLL running.
- `ST_ON_PLL`: PLL selected, PLL running.

The transitions are:

- `PLL_START`: from `ST_MAIN_PLL_OFF` to `ST_MAIN_PLL_ON`.
- `PLL_STOP`: from `ST_MAIN_PLL_ON` to `ST_MAIN_PLL_OFF`.
- `SWITCH_TO_PLL`: from `ST_MAIN_PLL_ON` to `ST_ON_PLL`. It needs the PLL-stable input.
- `SWITCH_TO_MAIN`: from `ST_ON_PLL` to `ST_MAIN_PLL_ON`.

Any write that asks for an illegal step leaves the state unchanged. As a result, software can never move the system clock onto a PLL that is stopped or not yet stable.

A sticky status bit records a power-on reset. A warm reset leaves it untouched, and software clears it by writing 1 to it.

Top module: `clk_src_ctl`

## Requirements
- R1: After any reset (power-on or warm), the control bits are: fast-select (bit 1) = 1, PLL power-down (bit 2) = 1, slow-select (bit 0) = 0, auxiliary enables (bits 3 and 4) = 0.
- R2: A power-on reset sets the status bit 5. A warm reset neither sets nor clears it.
- R3: Writing 1 to bit 5 clears the status bit. Writing 0 to bit 5 leaves it unchanged.
- R4: Bits 0, 3 and 4 take the written value on every write, with no restriction.
- R5: A write that clears bit 1 is ignored while bit 2 is 1 before the write.
- R6: A write that clears bit 1 is ignored while `pll_stable_i` is 0. With bit 2 = 0 and `pll_stable_i` = 1, the write takes effect.
- R7: A write that sets bit 2 is ignored while bit 1 is 0 before the write.
- R8: A single write that both sets bit 2 and clears bit 1 is rejected for both bits. The check uses the state before the write.
- R9: Once the PLL is selected, a later drop of `pll_stable_i` does not change bit 1 or bit 2.
- R10: Bits 7:6 always read 0 and ignore writes. Bits 4:0 of `rd_data` equal the five control outputs.
- R11: Without a write or a reset, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| pll_stable_i | input | 1 | PLL output has settled |
| slow_sel_o | output | 1 | 1 selects the 32.768 kHz oscillator for the slow clock, 0 the prescaled main clock |
| fast_sel_o | output | 1 | 1 selects the 12 MHz main clock for the system clock, 0 the PLL |
| pll_pd_o | output | 1 | 1 holds the PLL powered down |
| aux1_en_o | output | 1 | Auxiliary clock 1 enable |
| aux2_en_o | output | 1 | Auxiliary clock 2 enable |

## Verification
The hardest case to reach is the combined write that would set power-down and leave the PLL in the same cycle. It matters only in `ST_MAIN_PLL_ON` with the PLL stable, where each half alone would be legal. The directed sequence first starts the PLL, then issues that write. It also leaves `ST_ON_PLL` with a write that asks for power-down together with the return to the main clock, and drops `pll_stable_i` while the PLL is selected. After that, seeded random writes, random stability and occasional warm resets run against a bench model of the interlocks.

// File: rtl/clk_src_ctl_pkg.sv
package clk_src_ctl_pkg;
    localparam int REG_W    = 8;
    localparam int B_SLOW   = 0;
    localparam int B_FAST   = 1;
    localparam int B_PD     = 2;
    localparam int B_AUX0   = 3;
    localparam int NUM_AUX  = 2;
    localparam int B_POR    = B_AUX0 + NUM_AUX;
    localparam int CTRL_W   = B_POR;

    typedef enum logic [1:0] {
        ST_MAIN_PLL_OFF = 2'd0,
        ST_MAIN_PLL_ON  = 2'd1,
        ST_ON_PLL       = 2'd2
    } clk_state_e;
endpackage

// File: rtl/clk_sel_fsm.sv
module clk_sel_fsm
    import clk_src_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic req_fast,
    input  logic req_pd,
    input  logic pll_stable,
    output logic fast_sel,
    output logic pll_pd
);
    clk_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MAIN_PLL_OFF;
        else        state_q <= state_d;
    end

    // transitions, judged on the state before the write
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                ST_MAIN_PLL_OFF: begin
                    // PLL_START; leaving the main clock is refused while PLL is off
                    if (!req_pd) state_d = ST_MAIN_PLL_ON;
                end
                ST_MAIN_PLL_ON: begin
                    if (req_pd && req_fast)
                        state_d = ST_MAIN_PLL_OFF;            // PLL_STOP
                    else if (!req_pd && !req_fast && pll_stable)
                        state_d = ST_ON_PLL;                  // SWITCH_TO_PLL
                    // stop plus switch in one write: both refused
                end
                ST_ON_PLL: begin
                    // SWITCH_TO_MAIN; power-down request refused here
                    if (req_fast) state_d = ST_MAIN_PLL_ON;
                end
                default: state_d = ST_MAIN_PLL_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_MAIN_PLL_OFF: begin fast_sel = 1'b1; pll_pd = 1'b1; end
            ST_MAIN_PLL_ON:  begin fast_sel = 1'b1; pll_pd = 1'b0; end
            ST_ON_PLL:       begin fast_sel = 1'b0; pll_pd = 1'b0; end
            default:         begin fast_sel = 1'b1; pll_pd = 1'b1; end
        endcase
    end
endmodule

// File: rtl/clk_free_bits.sv
module clk_free_bits
    import clk_src_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_i,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic               slow_sel,
    output logic [NUM_AUX-1:0] aux_en,
    output logic               por_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slow_sel <= 1'b0;
        else if (wr_en) slow_sel <= wr_data[B_SLOW];
    end

    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     aux_en[g] <= 1'b0;
            else if (wr_en) aux_en[g] <= wr_data[B_AUX0+g];
        end
    end

    // sticky flag: set only by power-on reset, cleared by writing one
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)                        por_flag <= 1'b1;
        else if (wr_en && wr_data[B_POR]) por_flag <= 1'b0;
    end
endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
    import clk_src_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_i,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pll_stable_i,
    output logic             slow_sel_o,
    output logic             fast_sel_o,
    output logic             pll_pd_o,
    output logic             aux1_en_o,
    output logic             aux2_en_o
);
    logic               sys_rst_n;
    logic [NUM_AUX-1:0] aux_en;
    logic               por_flag;

    assign sys_rst_n = rst_n & ~por_i;

    clk_sel_fsm u_fsm (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .wr_en      (wr_en),
        .req_fast   (wr_data[B_FAST]),
        .req_pd     (wr_data[B_PD]),
        .pll_stable (pll_stable_i),
        .fast_sel   (fast_sel_o),
        .pll_pd     (pll_pd_o)
    );

    clk_free_bits u_free (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .por_i    (por_i),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .slow_sel (slow_sel_o),
        .aux_en   (aux_en),
        .por_flag (por_flag)
    );

    assign aux1_en_o = aux_en[0];
    assign aux2_en_o = aux_en[1];

    always_comb begin
        rd_data                      = '0;
        rd_data[B_SLOW]              = slow_sel_o;
        rd_data[B_FAST]              = fast_sel_o;
        rd_data[B_PD]                = pll_pd_o;
        rd_data[B_AUX0+:NUM_AUX]     = aux_en;
        rd_data[B_POR]               = por_flag;
    end
endmodule

// File: rtl/clk_src_ctl_chk.sv
module clk_src_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_i,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       pll_stable_i,
    input logic       fast_sel_o,
    input logic       pll_pd_o
);
    p_no_stopped_pll_r5: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        !(!fast_sel_o && pll_pd_o));

    p_switch_needs_stable_r6: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (!fast_sel_o && $past(fast_sel_o)) |-> $past(wr_en && pll_stable_i && !pll_pd_o));

    p_stop_needs_main_r7: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (pll_pd_o && !$past(pll_pd_o)) |-> $past(wr_en && fast_sel_o && wr_data[1]));

    p_por_clear_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (!rd_data[5] && $past(rd_data[5])) |-> $past(wr_en && wr_data[5]));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        !$past(wr_en) |-> $stable(rd_data));

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        rd_data[7:6] == 2'b00);
endmodule

bind clk_src_ctl clk_src_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_i        (por_i),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .pll_stable_i (pll_stable_i),
    .fast_sel_o   (fast_sel_o),
    .pll_pd_o     (pll_pd_o)
);

// File: tb/tb_clk_src_ctl.sv
`timescale 1ns/1ps
module tb_clk_src_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_i = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pll_stable_i = 1'b0;
    logic       slow_sel_o, fast_sel_o, pll_pd_o, aux1_en_o, aux2_en_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m = 8'h26;   // bench model of the register

    always #2 clk = ~clk;

    clk_src_ctl dut (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pll_stable_i(pll_stable_i), .slow_sel_o(slow_sel_o),
        .fast_sel_o(fast_sel_o), .pll_pd_o(pll_pd_o), .aux1_en_o(aux1_en_o),
        .aux2_en_o(aux2_en_o)
    );

    function automatic logic [7:0] model_write(logic [7:0] cur, logic [7:0] d, logic st);
        logic [7:0] n;
        logic clr_f, set_p;
        n = cur;
        n[0] = d[0]; n[3] = d[3]; n[4] = d[4];
        if (d[5]) n[5] = 1'b0;
        clr_f = cur[1] && !d[1];
        set_p = !cur[2] && d[2];
        if (!(clr_f && set_p)) begin
            if (d[1]) n[1] = 1'b1;
            else if (cur[1] && !cur[2] && st) n[1] = 1'b0;
            if (!d[2]) n[2] = 1'b0;
            else if (cur[1]) n[2] = 1'b1;
        end
        return n;
    endfunction

    task automatic check(string tag);
        logic [7:0] outs;
        outs = {3'b000, aux2_en_o, aux1_en_o, pll_pd_o, fast_sel_o, slow_sel_o};
        checks++;
        if (rd_data !== m || outs[4:0] !== m[4:0]) begin
            errors++;
            $display("FAIL %s: rd_data=%h outs=%h expected %h", tag, rd_data, outs, m);
        end
    endtask

    task automatic wr(logic [7:0] d, logic st);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; pll_stable_i = st;
        m = model_write(m, d, st);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n, logic st);
        @(negedge clk);
        pll_stable_i = st;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic warm_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m = {2'b00, m[5], 5'b00110};
    endtask

    task automatic power_on();
        @(negedge clk); por_i = 1'b1;
        @(negedge clk); por_i = 1'b0;
        m = 8'h26;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run hung");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        por_i = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m = 8'h26;
        @(negedge clk); check("R1 R2 power-on values");

        wr(8'h04, 1'b1); check("R5 clear fast while PLL off");
        wr(8'h02, 1'b1); check("R1 start PLL");
        wr(8'h00, 1'b0); check("R6 switch refused while unstable");
        wr(8'h04, 1'b1); check("R8 stop plus switch refused");
        wr(8'h00, 1'b1); check("R6 switch to PLL");
        idle(5, 1'b0);   check("R9 PLL kept after stable drops");
        wr(8'h04, 1'b0); check("R7 stop refused while on PLL");
        wr(8'h19, 1'b0); check("R4 slow and aux written");
        wr(8'hD9, 1'b0); check("R10 reserved ignore writes");
        wr(8'h1F, 1'b0); check("R7 back to main, stop refused");
        wr(8'h1F, 1'b0); check("R7 stop accepted on main");
        idle(4, 1'b1);   check("R11 hold without write");
        wr(8'h1F, 1'b1); check("R3 write 0 keeps status");
        wr(8'h3F, 1'b1); check("R3 write 1 clears status");
        warm_reset();    check("R2 warm reset leaves status clear");
        power_on();      check("R2 power-on sets status");
        wr(8'h1B, 1'b1);
        warm_reset();    check("R1 R2 warm reset keeps status");

        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            logic st;
            d = 8'($urandom);
            st = ($urandom % 4) != 0;
            if (($urandom % 40) == 0) warm_reset();
            else if (($urandom % 3) == 0) idle(1, st);
            else wr(d, st);
            check("R10 random against model");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule